// File: doc/BRIEF.md
# Built-In Logic Self-Test Engine

This block tests a small piece of combinational logic that sits inside it. A three-bit pseudorandom pattern source drives the embedded three-input, three-output logic. A three-bit multiple-input signature register folds each response into a running state. A counter ends the pass after seven pattern ticks. At that point the accumulated signature is compared with the known good value, and the block reports pass or fail.

A single start strobe launches a pass. While the pass runs, busy is high and the live compactor state can be seen on the signature port. When the pass ends, done and the verdict stay latched until the next accepted start. A fault select input is sampled at start. When it is set, the embedded logic is replaced by a copy that has a stuck-at-0 input. This lets a system prove that the checking path can detect a defect.

Top module: `lbist_engine`

## Requirements
- R1: After synchronous reset (active high), busy, done and pass are 0 and signature is 000.
- R2: When start is high and busy is low at a clock edge, the block sets busy, clears done and pass, loads the generator with 111 and clears the signature register to 000. These values are visible in the cycle that follows.
- R3: The generator state is {Q0,Q1,Q2}, with Q0 as the MSB. Each step sets Q1←Q0 and Q2←Q1, and Q0 takes Q1 XOR Q2. From 111 it visits 7,3,1,4,2,5,6 in turn and never reaches 000. The pattern feeds the logic as In[2:0] = {Q0,Q1,Q2}.
- R4: The fault-free logic computes Out[0] = In0|In1|In2, Out[1] = In0&In1&In2 and Out[2] = (In0&In1)|In2. The faulty copy forces the In2 term of the Out[2] OR to 0. The two copies first disagree on the fourth pattern (100).
- R5: With response r = Out[2:0], the signature register updates as s2←s1^r2, s1←s2^s0^r1 and s0←s2^r0. The response to a pattern is absorbed on the next clock. In the fault-free case, the signature across the seven busy cycles is 000,111,000,001,111,100,110.
- R6: fault_sel is captured at the accepted start, and later changes have no effect on that pass. In the faulty case, the signature across the busy cycles is 000,111,000,001,011,111,100. Once the faulty sequence diverges from the good one, it stays different.
- R7: A pass lasts exactly seven busy cycles. At the next edge busy falls, done rises and the signature keeps the value it had in the seventh cycle. Busy and done are never high together.
- R8: pass is 1 after a pass only if the final signature equals 110. The faulty case therefore ends with pass = 0.
- R9: A start pulse while busy is high is ignored, and the pass continues unchanged.
- R10: done, pass and signature hold their values from the end of a pass until the next accepted start.
- R11: A repeated pass with the same fault_sel reproduces the same signature sequence and verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch strobe, accepted only when idle |
| fault_sel | input | 1 | Selects the stuck-at-0 copy of the embedded logic for the next pass |
| busy | output | 1 | A test pass is running |
| done | output | 1 | A pass has completed; held until the next start |
| pass | output | 1 | Verdict: final signature matched the good value |
| signature | output | 3 | Live signature register state |

## Verification
The signature register drives a port directly. A wrong compactor update therefore shows on signature in the very next busy cycle. A wrong generator step or logic equation shows one cycle later, once the bad response has been absorbed. The XOR feedback keeps any divergence alive until the end of the pass, so the final verdict also flips. A control fault, such as an extra tick, a restart on a busy start or a verdict that is not held, shows on busy, done or pass at the cycle where the pass should have ended, or in the idle cycles after it.

// File: rtl/lbist_engine.sv
module lbist_engine #(
  parameter logic [2:0] GEN_SEED   = 3'b111,
  parameter logic [2:0] GOLDEN_SIG = 3'b110,
  parameter int         PASS_TICKS = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       fault_sel,
  output logic       busy,
  output logic       done,
  output logic       pass,
  output logic [2:0] signature
);
  localparam int CW = $clog2(PASS_TICKS + 1);
  localparam logic [CW-1:0] LAST_TICK = CW'(PASS_TICKS);

  logic [2:0]    gen_q;
  logic [2:0]    sig_q;
  logic [CW-1:0] tick_q;
  logic          fault_q;

  logic [2:0] gen_nxt, cut_in, cut_out, sig_nxt;
  logic       accept, last;

  assign gen_nxt = {gen_q[1] ^ gen_q[0], gen_q[2], gen_q[1]};

  assign cut_in     = gen_q;
  assign cut_out[0] = cut_in[0] | cut_in[1] | cut_in[2];
  assign cut_out[1] = cut_in[0] & cut_in[1] & cut_in[2];
  assign cut_out[2] = (cut_in[0] & cut_in[1]) | (cut_in[2] & ~fault_q);

  assign sig_nxt = {sig_q[1] ^ cut_out[2],
                    sig_q[2] ^ sig_q[0] ^ cut_out[1],
                    sig_q[2] ^ cut_out[0]};

  assign accept = start & ~busy;
  assign last   = busy & (tick_q == LAST_TICK);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      pass    <= 1'b0;
      gen_q   <= GEN_SEED;
      sig_q   <= '0;
      tick_q  <= '0;
      fault_q <= 1'b0;
    end else if (accept) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      pass    <= 1'b0;
      gen_q   <= GEN_SEED;
      sig_q   <= '0;
      tick_q  <= CW'(1);
      fault_q <= fault_sel;
    end else if (last) begin
      busy <= 1'b0;
      done <= 1'b1;
      pass <= (sig_q == GOLDEN_SIG);
    end else if (busy) begin
      gen_q  <= gen_nxt;
      sig_q  <= sig_nxt;
      tick_q <= tick_q + 1'b1;
    end
  end

  assign signature = sig_q;
endmodule

// File: rtl/lbist_engine_chk.sv
module lbist_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       pass,
  input logic [2:0] signature,
  input logic [2:0] gen_q,
  input logic [2:0] tick_q,
  input logic       fault_q
);
  AST_SEED_ON_START: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy && !done && !pass && signature == 3'b000 && gen_q == 3'b111); // R2
  AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    gen_q != 3'b000); // R3
  AST_GEN_STEP: assert property (@(posedge clk) disable iff (rst)
    busy && tick_q != 3'd7 |=> gen_q == {$past(gen_q[1]) ^ $past(gen_q[0]), $past(gen_q[2]), $past(gen_q[1])}); // R3
  AST_FAULT_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(fault_q)); // R6
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R7
  AST_END_OF_PASS: assert property (@(posedge clk) disable iff (rst)
    busy && tick_q == 3'd7 |=> done && !busy && $stable(signature)); // R7
  AST_VERDICT: assert property (@(posedge clk) disable iff (rst)
    done |-> pass == (signature == 3'b110)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    busy && tick_q != 3'd7 |=> busy && tick_q == $past(tick_q) + 3'd1); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done && $stable(pass) && $stable(signature)); // R10
endmodule

bind lbist_engine lbist_engine_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .pass(pass),
  .signature(signature), .gen_q(gen_q), .tick_q(tick_q), .fault_q(fault_q)
);

// File: tb/sim_lbist_engine.sv
`timescale 1ns/1ps
module sim_lbist_engine;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0, fault_sel = 1'b0;
  logic busy, done, pass;
  logic [2:0] signature;
  int errors = 0, checks = 0;

  lbist_engine u0 (.clk(clk), .rst(rst), .start(start), .fault_sel(fault_sel),
                   .busy(busy), .done(done), .pass(pass), .signature(signature));

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, got, exp);
    end
  endtask

  function automatic logic [2:0] exp_sig(input bit f, input int k);
    case (k)
      0: return 3'b000;
      1: return 3'b111;
      2: return 3'b000;
      3: return 3'b001;
      4: return f ? 3'b011 : 3'b111;
      5: return f ? 3'b111 : 3'b100;
      default: return f ? 3'b100 : 3'b110;
    endcase
  endfunction

  task automatic run_pass(input bit f, input bit poke, output logic [2:0] seen [7]);
    string tag;
    tag = poke ? "R9" : (f ? "R6" : "R5");
    @(negedge clk); fault_sel = f; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R2 busy", {2'b0, busy}, 3'd1);
    check("R2 done cleared", {2'b0, done}, 3'd0);
    check("R2 pass cleared", {2'b0, pass}, 3'd0);
    for (int k = 0; k < 7; k++) begin
      if (k > 0) @(negedge clk);
      if (poke && k == 2) begin start = 1'b1; fault_sel = ~f; end
      if (poke && k == 3) begin start = 1'b0; fault_sel = f; end
      seen[k] = signature;
      check($sformatf("%s sig tick %0d", tag, k + 1), signature, exp_sig(f, k));
      check("R7 busy during pass", {2'b0, busy}, 3'd1);
      if (k == 4) check("R4 first divergence", signature, exp_sig(f, 4));
    end
    @(negedge clk);
    check("R7 busy low", {2'b0, busy}, 3'd0);
    check("R7 done high", {2'b0, done}, 3'd1);
    check("R7 sig held", signature, exp_sig(f, 6));
    check("R3 final sig", signature, exp_sig(f, 6));
    check("R8 verdict", {2'b0, pass}, {2'b0, ~f});
    repeat (3) @(negedge clk);
    check("R10 done held", {2'b0, done}, 3'd1);
    check("R10 pass held", {2'b0, pass}, {2'b0, ~f});
    check("R10 sig held", signature, exp_sig(f, 6));
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 busy", {2'b0, busy}, 3'd0);
    check("R1 done", {2'b0, done}, 3'd0);
    check("R1 pass", {2'b0, pass}, 3'd0);
    check("R1 signature", signature, 3'b000);
    rst = 1'b0;
  endtask

  task automatic test_repeat(input bit f, input logic [2:0] first [7]);
    logic [2:0] again [7];
    run_pass(f, 1'b0, again);
    for (int k = 0; k < 7; k++)
      check($sformatf("R11 repeat tick %0d", k + 1), again[k], first[k]);
  endtask

  initial begin
    logic [2:0] good_seq [7];
    logic [2:0] bad_seq [7];
    logic [2:0] poke_seq [7];
    test_reset();
    run_pass(1'b0, 1'b0, good_seq);
    run_pass(1'b1, 1'b0, bad_seq);
    run_pass(1'b0, 1'b1, poke_seq);
    test_repeat(1'b0, good_seq);
    test_repeat(1'b1, bad_seq);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule